// File: doc/BRIEF.md
# Asynchronous Bus Cycle Terminator

This block sits on an asynchronous 16-bit processor bus and decides how each bus cycle ends. It watches the address strobe, the two byte data strobes and the read/write line. It drives three active-low termination outputs: data acknowledge, bus error and halt. A slave signals through `slave_rdy` that it has put read data on the bus or has latched write data. The block then acknowledges the cycle. If nobody answers, a programmable watchdog ends the access with bus error alone.

For memory protected by a data check, `chk_en` puts reads into check mode. In that mode acknowledge is held back until the checker reports completion on `chk_done`. A failed check (`chk_err`) ends the cycle in one of two ways, chosen by `chk_retry`. The first is bus error together with halt, which asks the processor to run the cycle again. The second is bus error together with acknowledge, which is an error termination.

All asynchronous bus inputs pass through two-flop synchronizers before the four-state termination machine uses them. The machine's states are idle, wait, terminate and release. A sticky flag records the most recent error and its cause until software pulses `err_clr`. The block carries no data, so it has no valid/ready stream interface. Every pin is a plain control or status signal.

Top module: `bus_term`

## Requirements
- R1: While reset is held, and after it is released, `dtack_n`, `berr_n` and `halt_n` are high and `err_valid` is low.
- R2: For a read (`rd_wr_n`=1) with check mode off, if `slave_rdy` is high when `as_n` falls, `dtack_n` alone goes low on the 4th rising clock edge after the fall. Bus error and halt stay high.
- R3: For a write (`rd_wr_n`=0), acknowledge needs `slave_rdy` and at least one of `uds_n`/`lds_n` low. It then arrives on the 4th rising edge. A write with both data strobes high is never acknowledged.
- R4: When no termination condition occurs, `berr_n` alone goes low on rising edge 4+L after `as_n` falls, where L is `wd_limit`. L=0 gives edge 4. `err_valid` is set, with `err_src`=0 meaning timeout.
- R5: In check mode (`chk_en`=1) on a read, acknowledge is withheld until `chk_done` is high. A check that never completes ends by the watchdog as in R4. A passing check gives `dtack_n` alone on the 4th edge.
- R6: A read whose check fails while `chk_retry`=1 drives `berr_n` and `halt_n` low on the same edge, with `dtack_n` high. `err_valid` is set with `err_src`=1 meaning check failure.
- R7: A read whose check fails while `chk_retry`=0 drives `berr_n` and `dtack_n` low on the same edge, with `halt_n` high. `err_valid` is set with `err_src`=1.
- R8: Once `as_n` rises, all asserted outputs stay low through the 2nd rising edge. They are released together on the 3rd rising edge: two synchronizer stages, then one clock in the machine. `halt_n` is never low while `berr_n` is high, so halt can never be released after bus error.
- R9: `err_valid` stays set until `err_clr` is pulsed. An error on the same edge as `err_clr` wins. A normal acknowledge leaves the flag as it was.
- R10: Check mode applies only to reads. A write is acknowledged as in R3 whatever `chk_done`, `chk_err` and `chk_retry` show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe, active low, asynchronous |
| uds_n | input | 1 | Upper data strobe, active low, asynchronous |
| lds_n | input | 1 | Lower data strobe, active low, asynchronous |
| rd_wr_n | input | 1 | 1 = read, 0 = write, asynchronous |
| slave_rdy | input | 1 | Slave has data on the bus or has latched it, asynchronous |
| chk_en | input | 1 | Check mode for reads |
| chk_done | input | 1 | Data check finished (synchronous) |
| chk_err | input | 1 | Data check failed, valid with chk_done |
| chk_retry | input | 1 | Failure response: 1 = bus error + halt, 0 = bus error + acknowledge |
| wd_limit | input | 8 | Watchdog limit in clocks |
| err_clr | input | 1 | Clears the sticky error flag |
| dtack_n | output | 1 | Data acknowledge, active low |
| berr_n | output | 1 | Bus error, active low |
| halt_n | output | 1 | Halt, active low |
| err_valid | output | 1 | Sticky error flag |
| err_src | output | 1 | Cause of last error: 0 timeout, 1 check failure |

## Verification
Some internal faults show up on the termination pins within a few clocks of the strobe that should cause them. A machine stuck outside wait shows no termination at all and hangs the cycle. A wrong watchdog count moves the bus error edge away from 4+L. A swapped failure response changes which pair of outputs falls together. A machine that does not leave terminate keeps the outputs low past the 3rd edge after the strobe rises. A fault in the sticky error logic shows only on `err_valid`/`err_src`, which is sampled on the edge where the termination appears.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_TERM = 2'd2,
    ST_REL  = 2'd3
  } bt_state_e;

  // active-high termination flags, inverted at the pins
  typedef struct packed {
    logic dtack;
    logic berr;
    logic halt;
  } term_t;
endpackage

// File: rtl/bt_sync.sv
module bt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bt_watchdog.sv
module bt_watchdog #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  assign expired = run && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end

  // R4: the count never runs past the limit while waiting
  a_r4_cnt_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (run && expired && !clr) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/bt_fsm.sv
module bt_fsm
  import bus_term_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  as_act,
  input  logic  ds_act,
  input  logic  rd,
  input  logic  rdy,
  input  logic  chk_en,
  input  logic  chk_done,
  input  logic  chk_err,
  input  logic  chk_retry,
  input  logic  wd_expired,
  output logic  wd_clr,
  output logic  wd_run,
  output term_t term_q,
  output logic  err_set,
  output logic  err_chk
);
  bt_state_e state, state_nxt;
  term_t     term_nxt;
  logic      chk_path, data_ok;

  assign wd_clr   = (state == ST_IDLE);
  assign wd_run   = (state == ST_WAIT);
  assign chk_path = chk_en && rd;
  assign data_ok  = rdy && (rd || ds_act);

  always_comb begin
    state_nxt = state;
    term_nxt  = term_q;
    err_set   = 1'b0;
    err_chk   = 1'b0;
    unique case (state)
      ST_IDLE: if (as_act) state_nxt = ST_WAIT;
      ST_WAIT: begin
        if (!as_act) begin
          state_nxt = ST_REL;
        end else if (data_ok && (!chk_path || chk_done)) begin
          state_nxt = ST_TERM;
          if (chk_path && chk_err) begin
            err_set  = 1'b1;
            err_chk  = 1'b1;
            term_nxt = chk_retry ? '{dtack: 1'b0, berr: 1'b1, halt: 1'b1}
                                 : '{dtack: 1'b1, berr: 1'b1, halt: 1'b0};
          end else begin
            term_nxt = '{dtack: 1'b1, berr: 1'b0, halt: 1'b0};
          end
        end else if (wd_expired) begin
          state_nxt = ST_TERM;
          err_set   = 1'b1;
          term_nxt  = '{dtack: 1'b0, berr: 1'b1, halt: 1'b0};
        end
      end
      ST_TERM: if (!as_act) begin
        state_nxt = ST_REL;
        term_nxt  = '0;
      end
      ST_REL: state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      term_q <= '0;
    end else begin
      state  <= state_nxt;
      term_q <= term_nxt;
    end
  end

  // R8: leaving terminate drops every termination output
  a_r8_release_all: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TERM && !as_act) |=> (term_q == '0));
  // R2: outputs only active while the machine is terminating
  a_r2_term_only_in_term: assert property (@(posedge clk) disable iff (!rst_n)
    (term_q != '0) |-> (state == ST_TERM));
endmodule

// File: rtl/bus_term.sv
module bus_term
  import bus_term_pkg::*;
#(
  parameter int WD_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_n,
  input  logic            uds_n,
  input  logic            lds_n,
  input  logic            rd_wr_n,
  input  logic            slave_rdy,
  input  logic            chk_en,
  input  logic            chk_done,
  input  logic            chk_err,
  input  logic            chk_retry,
  input  logic [WD_W-1:0] wd_limit,
  input  logic            err_clr,
  output logic            dtack_n,
  output logic            berr_n,
  output logic            halt_n,
  output logic            err_valid,
  output logic            err_src
);
  localparam int SYNC_W = 5;
  localparam logic [SYNC_W-1:0] SYNC_RST = 5'b11110;

  logic [SYNC_W-1:0] raw_bus, syn_bus;
  logic  as_s, uds_s, lds_s, rd_s, rdy_s;
  logic  wd_clr, wd_run, wd_expired, err_set, err_chk;
  term_t term_q;

  assign raw_bus = {as_n, uds_n, lds_n, rd_wr_n, slave_rdy};
  assign {as_s, uds_s, lds_s, rd_s, rdy_s} = syn_bus;

  bt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(syn_bus)
  );

  bt_watchdog #(.CNT_W(WD_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .clr(wd_clr), .run(wd_run),
    .limit(wd_limit), .expired(wd_expired)
  );

  bt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .as_act(!as_s), .ds_act(!uds_s || !lds_s), .rd(rd_s), .rdy(rdy_s),
    .chk_en(chk_en), .chk_done(chk_done), .chk_err(chk_err),
    .chk_retry(chk_retry), .wd_expired(wd_expired),
    .wd_clr(wd_clr), .wd_run(wd_run), .term_q(term_q),
    .err_set(err_set), .err_chk(err_chk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_src   <= 1'b0;
    end else if (err_set) begin
      err_valid <= 1'b1;
      err_src   <= err_chk;
    end else if (err_clr) begin
      err_valid <= 1'b0;
    end
  end

  assign dtack_n = !term_q.dtack;
  assign berr_n  = !term_q.berr;
  assign halt_n  = !term_q.halt;

  // R8: halt only together with bus error
  a_r8_halt_needs_berr: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |-> !berr_n);
  // R8: bus error and halt leave together
  a_r8_joint_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!berr_n && !halt_n) |=> (berr_n == halt_n));
  // R6/R7: acknowledge and halt never together
  a_r7_no_dtack_with_halt: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !halt_n));
  // R9: every bus error leaves the sticky flag set
  a_r9_berr_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(berr_n) |-> err_valid);
endmodule

// File: tb/tb_bus_term.sv
module tb_bus_term;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic       rd;
    logic       ds;
    logic       rdy;
    logic       ce;
    logic       cd;
    logic       cerr;
    logic       rt;
    logic [7:0] lim;
    logic       exp_d;
    logic       exp_b;
    logic       exp_h;
    logic [7:0] lat;
    logic       ev;
    logic       es;
    logic [3:0] req;
  } vec_t;

  // rd ds rdy ce cd cerr rt lim   d b h  lat  ev es req
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'd9, 1'b1,1'b0,1'b0,8'd4, 1'b0,1'b0,4'd2},  // R2 read
    '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'd9, 1'b1,1'b0,1'b0,8'd4, 1'b0,1'b0,4'd3},  // R3 write
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,8'd6, 1'b0,1'b1,1'b0,8'd10,1'b1,1'b0,4'd3},  // R3 write no strobe
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'd3, 1'b0,1'b1,1'b0,8'd7, 1'b1,1'b0,4'd4},  // R4 timeout
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'd9, 1'b1,1'b0,1'b0,8'd4, 1'b0,1'b0,4'd5},  // R5 check pass
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd9, 1'b0,1'b1,1'b1,8'd4, 1'b1,1'b1,4'd6},  // R6 retry
    '{1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,8'd9, 1'b1,1'b1,1'b0,8'd4, 1'b1,1'b1,4'd7},  // R7 error
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'd2, 1'b0,1'b1,1'b0,8'd6, 1'b1,1'b0,4'd5},  // R5 never done
    '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,8'd9, 1'b1,1'b0,1'b0,8'd4, 1'b0,1'b0,4'd10}, // R10 write ignores check
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'd0, 1'b0,1'b1,1'b0,8'd4, 1'b1,1'b0,4'd4}   // R4 limit zero
  };

  logic clk = 1'b0;
  logic rst_n;
  logic as_n, uds_n, lds_n, rd_wr_n, slave_rdy;
  logic chk_en, chk_done, chk_err, chk_retry, err_clr;
  logic [7:0] wd_limit;
  logic dtack_n, berr_n, halt_n, err_valid, err_src;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_term dut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rd_wr_n(rd_wr_n), .slave_rdy(slave_rdy), .chk_en(chk_en),
    .chk_done(chk_done), .chk_err(chk_err), .chk_retry(chk_retry),
    .wd_limit(wd_limit), .err_clr(err_clr), .dtack_n(dtack_n),
    .berr_n(berr_n), .halt_n(halt_n), .err_valid(err_valid), .err_src(err_src)
  );

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] outs();
    return {~dtack_n, ~berr_n, ~halt_n};
  endfunction

  // drives one bus cycle; returns latency, outputs and sticky flag at termination
  task automatic run_vec(input vec_t v, input int req, input logic hold_clr,
                         output int lat, output logic [2:0] seen,
                         output logic ev, output logic es);
    @(negedge clk);
    rd_wr_n = v.rd; uds_n = !v.ds; lds_n = 1'b1; slave_rdy = v.rdy;
    chk_en = v.ce; chk_done = v.cd; chk_err = v.cerr; chk_retry = v.rt;
    wd_limit = v.lim; err_clr = hold_clr; as_n = 1'b0;
    lat = 0; seen = 3'b000; ev = 1'b0; es = 1'b0;
    for (int i = 1; i <= 64; i++) begin
      @(posedge clk); @(negedge clk);
      if (outs() != 3'b000) begin
        lat = i; seen = outs(); ev = err_valid; es = err_src;
        break;
      end
    end
    as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; slave_rdy = 1'b0;
    err_clr = 1'b0;
    if (lat != 0) begin
      @(posedge clk); @(negedge clk);
      check(8, "held after 1st edge", {29'd0, outs()}, {29'd0, seen});
      @(posedge clk); @(negedge clk);
      check(8, "held after 2nd edge", {29'd0, outs()}, {29'd0, seen});
      @(posedge clk); @(negedge clk);
      check(8, "released on 3rd edge", {29'd0, outs()}, 32'd0);
      check(req, "release from vector", {29'd0, outs()}, 32'd0);
    end
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [2:0] seen;
    logic ev, es;
    rst_n = 1'b0; as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1; rd_wr_n = 1'b1;
    slave_rdy = 1'b0; chk_en = 1'b0; chk_done = 1'b0; chk_err = 1'b0;
    chk_retry = 1'b0; wd_limit = 8'd9; err_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check(1, "outputs in reset", {29'd0, outs()}, 32'd0);
    check(1, "err_valid in reset", {31'd0, err_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 after reset
    check(1, "outputs after reset", {29'd0, outs()}, 32'd0);
    check(1, "err_valid after reset", {31'd0, err_valid}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      run_vec(v, int'(v.req), 1'b0, lat, seen, ev, es);
      check(int'(v.req), $sformatf("vec %0d latency", k), lat, {24'd0, v.lat});
      check(int'(v.req), $sformatf("vec %0d outputs", k), {29'd0, seen},
            {29'd0, v.exp_d, v.exp_b, v.exp_h});
      check(int'(v.req), $sformatf("vec %0d err_valid", k), {31'd0, ev}, {31'd0, v.ev});
      if (v.ev) check(int'(v.req), $sformatf("vec %0d err_src", k), {31'd0, es}, {31'd0, v.es});
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      check(9, "cleared by pulse", {31'd0, err_valid}, 32'd0);
    end

    // R9: error on the same edge as a held clear still sets the flag
    run_vec(VECS[3], 9, 1'b1, lat, seen, ev, es);
    check(9, "set wins over clear", {31'd0, ev}, 32'd1);
    check(9, "source timeout", {31'd0, es}, 32'd0);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;

    // R9: flag is sticky across idle time and a normal acknowledge
    run_vec(VECS[5], 9, 1'b0, lat, seen, ev, es);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(9, "sticky while idle", {31'd0, err_valid}, 32'd1);
    run_vec(VECS[0], 9, 1'b0, lat, seen, ev, es);
    check(9, "normal read keeps flag", {31'd0, ev}, 32'd1);
    check(9, "normal read keeps source", {31'd0, es}, 32'd1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check(9, "clear after sticky", {31'd0, err_valid}, 32'd0);

    // R3: lower strobe alone also qualifies a write
    begin
      vec_t w;
      w = VECS[1];
      @(negedge clk);
      rd_wr_n = 1'b0; lds_n = 1'b0; uds_n = 1'b1; slave_rdy = 1'b1;
      chk_en = 1'b0; wd_limit = 8'd9; as_n = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(3, "lower strobe write ack", {29'd0, outs()}, {29'd0, w.exp_d, w.exp_b, w.exp_h});
      as_n = 1'b1; lds_n = 1'b1; slave_rdy = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(8, "lower strobe release", {29'd0, outs()}, 32'd0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule